// File: doc/BRIEF.md
# Tracking Sigma-Delta Converter Core

This block is the digital side of a low-cost, slow analog-to-digital converter. Outside the chip there is only a resistor-capacitor low-pass filter and a comparator. Inside, an up/down counter holds the running estimate of the analog input. A first-order sigma-delta modulator turns that estimate into a one-bit stream, `bit_out`. The external filter smooths this stream into an analog level. The comparator sets that level against the real input and feeds one bit back on `cmp_in`.

When the input is above the filtered level, the counter steps up by one LSB; otherwise it steps down. The accumulator's integral action makes the average count equal the input voltage in steady state. The low counter bits carry the limit-cycle oscillation, so only the top bits are published on `result`. A one-clock strobe, `result_vld`, marks each refresh.

All logic runs on the fast system clock. The slow converter rate is a clock enable produced by a programmable divider. A second divider can make the counter update less often than the modulator runs, which reduces the relative oscillation.

Top module: `sd_track_adc`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets: the counter goes to mid-scale, so `result` reads 2^(OUT_W-1) (512 by default), and both `bit_out` and `result_vld` are 0.
- R2: The modulator advances once every `div_ratio`+1 system clocks. The counter updates once every `upd_ratio`+1 modulator steps. `result_vld` therefore pulses once every (`div_ratio`+1)·(`upd_ratio`+1) clocks.
- R3: `cmp_in` passes through two flops before it is used. When the synchronised bit is 1, each counter update adds one LSB; when it is 0, each update subtracts one LSB.
- R4: A steady high comparator drives the counter to all-ones, where it stays: `result` holds 2^OUT_W-1 and never wraps to 0.
- R5: A steady low comparator drives the counter to zero, where it stays: `result` holds 0 and never wraps to full scale.
- R6: On each modulator step, the counter value is added to a CNT_W-bit accumulator, and the carry out of that sum becomes `bit_out`. As a result, the density of ones equals counter/2^CNT_W. With the counter at zero the stream is all zeros. At all-ones it has at most one zero in any 2^CNT_W steps.
- R7: When the loop is closed through a first-order low-pass filter and a comparator, the average of `result` settles to within 12 LSB of the input's fraction of full scale times 2^OUT_W.
- R8: `result` equals the top OUT_W bits of the counter. It changes only in a clock where `result_vld` is 1, and by at most one LSB. When the combined division is above 1, `result_vld` lasts one clock.
- R9: `bit_out` changes only on a modulator step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ratio | input | DIV_W | Modulator step period minus one, in system clocks |
| upd_ratio | input | UPD_W | Counter update period minus one, in modulator steps |
| cmp_in | input | 1 | Asynchronous comparator result (1 = input above filtered stream) |
| bit_out | output | 1 | One-bit stream to the external filter |
| result | output | OUT_W | Conversion result, top bits of the counter |
| result_vld | output | 1 | One-clock strobe when `result` is refreshed |

## Verification
The converter is run in closed loop against a modelled filter and comparator at four input levels (a quarter, half, 0.7 and 0.9 of full scale). Each level uses a different pair of rate settings. These runs tell correct tracking apart from sign errors, truncation errors and modulator errors, and they also measure the strobe period for each rate pair. Open-loop runs with the comparator forced high and then low drive the counter into both rails. Those runs separate saturation from wrap-around, and counting ones in the stream shows the modulator's density at the two extremes.

// File: rtl/sdt_pkg.sv
// Shared types for the tracking sigma-delta converter.
// Assumes nothing beyond IEEE 1800-2017.
package sdt_pkg;
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/sdt_tick_gen.sv
// Clock-enable divider: outputs one tick every (ratio+1) enabled clocks.
// Assumes ratio may change at any time; the count clears when it reaches or passes ratio.
module sdt_tick_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] ratio,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = en && (cnt_q >= ratio);

    // Count enabled clocks and restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_q >= ratio) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdt_sync.sv
// Synchroniser chain for the asynchronous comparator bit.
// Assumes STAGES >= 2; the output is held at 0 during reset.
module sdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdt_counter.sv
// Saturating up/down tracking counter, one LSB per enabled step.
// Assumes a mid-scale start; it holds at zero and at all-ones instead of wrapping.
module sdt_counter
    import sdt_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  step_dir_e    dir,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_MID = {1'b1, {(W-1){1'b0}}};

    // Step toward the comparator's verdict, clamped at both rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MID;
        end else if (step_en) begin
            if (dir == STEP_UP) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdt_modulator.sv
// First-order sigma-delta modulator: adds the level into a W-bit accumulator each step.
// The carry out of that sum is the registered stream bit. Assumes level is unsigned.
module sdt_modulator #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] level,
    output logic         bit_q
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, level};

    // Accumulate on each step; the carry becomes the stream bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else if (en) begin
            acc_q <= sum[W-1:0];
            bit_q <= sum[W];
        end
    end
endmodule

// File: rtl/sd_track_adc.sv
// Tracking sigma-delta converter core (digital half).
// The counter estimate drives a modulator whose stream is filtered off chip. The compared
// result steers the counter, and the top counter bits are the result.
// Assumes one clock domain, with slow rates set as clock enables.
module sd_track_adc
    import sdt_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int OUT_W = 10,
    parameter int DIV_W = 8,
    parameter int UPD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio,
    input  logic [UPD_W-1:0] upd_ratio,
    input  logic             cmp_in,
    output logic             bit_out,
    output logic [OUT_W-1:0] result,
    output logic             result_vld
);
    localparam int SYNC_STAGES = 2;

    logic             adc_tick;
    logic             upd_tick;
    logic             cmp_sync;
    logic [CNT_W-1:0] level;
    step_dir_e        dir;

    sdt_tick_gen #(.W(DIV_W)) u_adc_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .ratio (div_ratio),
        .tick  (adc_tick)
    );

    sdt_tick_gen #(.W(UPD_W)) u_upd_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adc_tick),
        .ratio (upd_ratio),
        .tick  (upd_tick)
    );

    sdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_sync)
    );

    assign dir = cmp_sync ? STEP_UP : STEP_DOWN;

    sdt_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (upd_tick),
        .dir     (dir),
        .cnt_q   (level)
    );

    sdt_modulator #(.W(CNT_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adc_tick),
        .level (level),
        .bit_q (bit_out)
    );

    // Flag the clock in which the refreshed counter becomes visible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vld <= 1'b0;
        end else begin
            result_vld <= upd_tick;
        end
    end

    assign result = level[CNT_W-1 -: OUT_W];
endmodule

// File: rtl/sd_track_adc_chk.sv
// Property checker for sd_track_adc, attached by bind.
// Assumes it sees the top ports plus the internal modulator step enable.
module sd_track_adc_chk #(
    parameter int OUT_W = 10,
    parameter int DIV_W = 8,
    parameter int UPD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_ratio,
    input logic [UPD_W-1:0] upd_ratio,
    input logic             bit_out,
    input logic [OUT_W-1:0] result,
    input logic             result_vld,
    input logic             adc_tick
);
    localparam logic [OUT_W-1:0] OUT_MAX = {OUT_W{1'b1}};

    // R8: result moves only in a strobe clock
    a_r8_change_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> result_vld);

    // R8: at most one LSB per refresh
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> (result == $past(result) || result == $past(result) + 1'b1
                        || result == $past(result) - 1'b1));

    // R4: no wrap from full scale to zero
    a_r4_no_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(result) == OUT_MAX) |-> (result != '0));

    // R5: no wrap from zero to full scale
    a_r5_no_bottom_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(result) == '0) |-> (result != OUT_MAX));

    // R9: the stream bit holds between modulator steps
    a_r9_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_tick |=> $stable(bit_out));

    // R8: strobe is a single clock when the rates divide
    a_r8_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld && (div_ratio != '0 || upd_ratio != '0)
         && $stable(div_ratio) && $stable(upd_ratio)) |=> !result_vld);
endmodule

bind sd_track_adc sd_track_adc_chk #(
    .OUT_W(OUT_W),
    .DIV_W(DIV_W),
    .UPD_W(UPD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_ratio  (div_ratio),
    .upd_ratio  (upd_ratio),
    .bit_out    (bit_out),
    .result     (result),
    .result_vld (result_vld),
    .adc_tick   (adc_tick)
);

// File: tb/tb_sd_track_adc.sv
module tb_sd_track_adc;
    localparam int CNT_W = 14;
    localparam int OUT_W = 10;
    localparam int DIV_W = 8;
    localparam int UPD_W = 4;
    localparam int NROW  = 4;
    localparam int VIN_M [NROW] = '{250, 500, 700, 900};
    localparam int DIV_T [NROW] = '{0, 1, 0, 1};
    localparam int UPD_T [NROW] = '{0, 0, 1, 1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_ratio = '0;
    logic [UPD_W-1:0] upd_ratio = '0;
    logic             cmp_in;
    logic             bit_out;
    logic [OUT_W-1:0] result;
    logic             result_vld;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  loop_on = 1'b0;
    bit  cmp_force = 1'b0;
    real vin = 0.5;
    real filt = 0.5;

    always #5 clk = ~clk;

    sd_track_adc #(.CNT_W(CNT_W), .OUT_W(OUT_W), .DIV_W(DIV_W), .UPD_W(UPD_W)) dut (
        .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .upd_ratio(upd_ratio),
        .cmp_in(cmp_in), .bit_out(bit_out), .result(result), .result_vld(result_vld)
    );

    // Off-chip filter and comparator model, advanced away from the active edge.
    always @(negedge clk) begin
        filt = filt + ((bit_out ? 1.0 : 0.0) - filt) / 256.0;
        cmp_in = loop_on ? (vin > filt) : cmp_force;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_vld();
        do @(negedge clk); while (!result_vld);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cmp_in = 1'b0;
        // R1: reset state
        clocks(4);
        check(result == 10'd512, "R1 result", int'(result), 512);
        check(bit_out == 1'b0, "R1 bit_out", int'(bit_out), 0);
        check(result_vld == 1'b0, "R1 vld", int'(result_vld), 0);
        rst_n = 1'b1;
        loop_on = 1'b1;

        // Table walk: closed-loop tracking (R7, R3) and strobe period (R2, R8)
        for (int r = 0; r < NROW; r++) begin
            int prev_m;
            int upd_n;
            int per;
            int gap;
            int hi;
            int expv;
            real acc;
            prev_m = (r == 0) ? 500 : VIN_M[r-1];
            div_ratio = DIV_T[r][DIV_W-1:0];
            upd_ratio = UPD_T[r][UPD_W-1:0];
            vin = VIN_M[r] / 1000.0;
            per = (DIV_T[r] + 1) * (UPD_T[r] + 1);
            upd_n = ((VIN_M[r] > prev_m ? VIN_M[r] - prev_m : prev_m - VIN_M[r]) * 16384) / 1000 + 2000;
            clocks(upd_n * per);
            wait_vld();
            gap = 0;
            hi = 0;
            do begin
                @(negedge clk);
                gap++;
                if (result_vld) hi++;
            end while (!result_vld);
            check(gap == per, "R2 strobe period", gap, per);
            if (per > 1) begin
                @(negedge clk);
                check(result_vld == 1'b0, "R8 strobe one clock", int'(result_vld), 0);
            end
            acc = 0.0;
            for (int i = 0; i < 4096; i++) begin
                @(negedge clk);
                acc = acc + real'(result);
            end
            acc = acc / 4096.0;
            expv = (VIN_M[r] * 1024) / 1000;
            check((acc > expv - 12.0) && (acc < expv + 12.0), "R7 tracking average", int'(acc), expv);
        end

        // R4/R3: comparator forced high drives counter up to the top rail
        loop_on = 1'b0;
        div_ratio = '0;
        upd_ratio = '0;
        cmp_force = 1'b1;
        clocks(17000);
        check(result == 10'd1023, "R4 top rail", int'(result), 1023);
        begin
            int ones;
            ones = 0;
            for (int i = 0; i < 1024; i++) begin
                @(negedge clk);
                if (bit_out) ones++;
            end
            check(ones >= 1023, "R6 density at all-ones", ones, 1023);
        end
        clocks(500);
        check(result == 10'd1023, "R4 holds without wrap", int'(result), 1023);

        // R5/R3: comparator forced low drives counter down to zero
        cmp_force = 1'b0;
        clocks(100);
        check(result < 10'd1023, "R3 steps down on low", int'(result), 1022);
        clocks(17000);
        check(result == 10'd0, "R5 bottom rail", int'(result), 0);
        clocks(20);
        begin
            int ones;
            ones = 0;
            for (int i = 0; i < 1024; i++) begin
                @(negedge clk);
                if (bit_out) ones++;
            end
            check(ones == 0, "R6 density at zero", ones, 0);
        end
        check(result == 10'd0, "R5 holds without wrap", int'(result), 0);

        // R1: reset mid-run restores mid-scale
        rst_n = 1'b0;
        clocks(2);
        check(result == 10'd512, "R1 reset again", int'(result), 512);
        check(bit_out == 1'b0, "R1 bit after reset", int'(bit_out), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule